// File: doc/BRIEF.md
# Tagged Issue Ring with Dataflow Wakeup

This block is the instruction window of an out-of-order core. It is a circular buffer of slots, and each slot's index serves as the tag of the result it will produce. Decode writes instructions into the ring in program order. Each of the two sources arrives either as a ready value or as the tag of the slot that will produce it.

Every cycle, a picker sends one slot with all operands present to the functional units. The slot it chooses is the oldest such slot counting from the head. When a unit finishes, it drives a completion bus with a tag, a result and a cause code. Every operand waiting on that tag captures the value. The producing slot records its result and is marked done.

The head slot leaves the ring once it is done, so results reach architectural state strictly in program order. If the leaving slot carries a non-zero cause, it is reported as an exception, and every younger slot is discarded by pulling the allocation pointer back to the commit pointer.

Top module: `ooo_issue_ring`

## Requirements
- R1: Accepted allocations take slots in ring order. `alloc_tag` shows the slot the next allocation will use: it starts at 0 and goes up by one modulo DEPTH per accepted allocation. `alloc_ready` is low while all DEPTH slots are occupied, and an allocation offered in that state changes nothing.
- R2: A slot is dispatched only when it is allocated, has not been dispatched yet and has both operands present. At most one slot is dispatched per cycle, and no slot is dispatched twice. Dispatch appears combinationally on `issue_*` in the cycle after the last condition becomes true.
- R3: When several slots are eligible, the one nearest the head in ring order is dispatched, even when its index is numerically larger than the index of a younger eligible slot.
- R4: A completion with tag T and data D makes every allocated operand waiting on T present with value D. The waiting operand holds the tag T in the low bits of its source field. The dispatched operand then shows D.
- R5: An allocation whose source names the tag being completed in that same cycle stores that operand as present with the completed data.
- R6: `retire_valid` is high only when the head slot is allocated and has completed. Retirement proceeds strictly in slot order and reports the tag, destination flag, destination register, result and cause. A completed younger slot never retires ahead of an incomplete older one.
- R7: A retiring slot with a non-zero cause raises `retire_exc`, and `alloc_ready` is low in that cycle. Afterwards the ring is empty, and the next allocation takes the slot that follows the excepting one. Younger slots, completed or not, never retire and are never dispatched again.
- R8: After reset the ring is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `issue_valid` and `retire_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode offers an instruction |
| alloc_ready | output | 1 | Offer is accepted this cycle |
| alloc_tag | output | IDX_W | Slot the next allocation takes |
| alloc_op | input | OP_W | Operation code |
| alloc_a_ready | input | 1 | Source A is a value (1) or a tag (0) |
| alloc_a | input | DATA_W | Source A value, or producer tag in low bits |
| alloc_b_ready | input | 1 | Source B is a value (1) or a tag (0) |
| alloc_b | input | DATA_W | Source B value, or producer tag in low bits |
| alloc_wr | input | 1 | Instruction writes a register |
| alloc_dest | input | REG_W | Destination register |
| issue_valid | output | 1 | A slot is dispatched this cycle |
| issue_tag | output | IDX_W | Dispatched slot |
| issue_op | output | OP_W | Dispatched operation |
| issue_a | output | DATA_W | Dispatched operand A |
| issue_b | output | DATA_W | Dispatched operand B |
| done_valid | input | 1 | Completion bus active |
| done_tag | input | IDX_W | Completing slot |
| done_data | input | DATA_W | Result |
| done_cause | input | CAUSE_W | Exception cause, 0 for none |
| retire_valid | output | 1 | Head slot leaves the ring this cycle |
| retire_tag | output | IDX_W | Retiring slot |
| retire_wr | output | 1 | Retiring slot writes a register |
| retire_dest | output | REG_W | Its destination register |
| retire_data | output | DATA_W | Its result |
| retire_cause | output | CAUSE_W | Its cause code |
| retire_exc | output | 1 | Retiring slot raises an exception |

## Verification
Several corner cases get targeted stimulus:

- **Full ring.** An allocation is offered while the ring is full. A design that accepted it would overwrite the in-flight head, and that slot would then never retire.
- **Wrapped order.** Two operands wake together while the ring has wrapped, so the older slot has the larger index. A lowest-index picker would dispatch them in the wrong order.
- **Same-cycle capture.** An allocation names the tag being completed in the same cycle. A design that missed this would leave that slot waiting forever.
- **In-order retirement.** A younger slot completes before its elder, which would expose out-of-order retirement.
- **Exception flush.** An exception leaves completed younger slots behind. A design that did not collapse the pointers would retire them or hand out the wrong next tag.

// File: rtl/ooo_issue_ring.sv
module ooo_issue_ring #(
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 8,
  parameter int OP_W    = 3,
  parameter int REG_W   = 3,
  parameter int CAUSE_W = 2,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int PTR_W  = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  output logic [IDX_W-1:0]   alloc_tag,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic               alloc_a_ready,
  input  logic [DATA_W-1:0]  alloc_a,
  input  logic               alloc_b_ready,
  input  logic [DATA_W-1:0]  alloc_b,
  input  logic               alloc_wr,
  input  logic [REG_W-1:0]   alloc_dest,
  output logic               issue_valid,
  output logic [IDX_W-1:0]   issue_tag,
  output logic [OP_W-1:0]    issue_op,
  output logic [DATA_W-1:0]  issue_a,
  output logic [DATA_W-1:0]  issue_b,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_tag,
  input  logic [DATA_W-1:0]  done_data,
  input  logic [CAUSE_W-1:0] done_cause,
  output logic               retire_valid,
  output logic [IDX_W-1:0]   retire_tag,
  output logic               retire_wr,
  output logic [REG_W-1:0]   retire_dest,
  output logic [DATA_W-1:0]  retire_data,
  output logic [CAUSE_W-1:0] retire_cause,
  output logic               retire_exc
);

  logic [PTR_W-1:0] head_q, tail_q;
  logic [DEPTH-1:0] use_q, exec_q, done_q, pa_q, pb_q, wr_q;
  logic [DATA_W-1:0] va_q [DEPTH];
  logic [DATA_W-1:0] vb_q [DEPTH];
  logic [DATA_W-1:0] res_q [DEPTH];
  logic [OP_W-1:0]   op_q [DEPTH];
  logic [REG_W-1:0]  dest_q [DEPTH];
  logic [CAUSE_W-1:0] cause_q [DEPTH];

  wire [IDX_W-1:0] head_idx = head_q[IDX_W-1:0];
  wire [IDX_W-1:0] tail_idx = tail_q[IDX_W-1:0];
  wire full = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);
  wire [DEPTH-1:0] eligible = use_q & ~exec_q & pa_q & pb_q;

  assign retire_valid = use_q[head_idx] & done_q[head_idx];
  assign retire_tag   = head_idx;
  assign retire_wr    = wr_q[head_idx];
  assign retire_dest  = dest_q[head_idx];
  assign retire_data  = res_q[head_idx];
  assign retire_cause = cause_q[head_idx];
  assign retire_exc   = retire_valid & (|cause_q[head_idx]);

  assign alloc_ready = !full && !retire_exc;
  assign alloc_tag   = tail_idx;
  wire alloc_fire    = alloc_valid && alloc_ready;

  wire a_hit = done_valid && (alloc_a[IDX_W-1:0] == done_tag);
  wire b_hit = done_valid && (alloc_b[IDX_W-1:0] == done_tag);

  logic [IDX_W-1:0] pick;
  always_comb begin
    issue_valid = 1'b0;
    pick = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] j;
      j = head_idx + IDX_W'(k);
      if (eligible[j]) begin
        issue_valid = 1'b1;
        pick = j;
      end
    end
  end

  assign issue_tag = pick;
  assign issue_op  = op_q[pick];
  assign issue_a   = va_q[pick];
  assign issue_b   = vb_q[pick];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      use_q  <= '0;
      exec_q <= '0;
      done_q <= '0;
      pa_q   <= '0;
      pb_q   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (done_valid && use_q[i] && !pa_q[i] && va_q[i][IDX_W-1:0] == done_tag) begin
          pa_q[i] <= 1'b1;
          va_q[i] <= done_data;
        end
        if (done_valid && use_q[i] && !pb_q[i] && vb_q[i][IDX_W-1:0] == done_tag) begin
          pb_q[i] <= 1'b1;
          vb_q[i] <= done_data;
        end
      end
      if (issue_valid) exec_q[pick] <= 1'b1;
      if (done_valid) begin
        done_q[done_tag]  <= 1'b1;
        res_q[done_tag]   <= done_data;
        cause_q[done_tag] <= done_cause;
      end
      if (alloc_fire) begin
        use_q[tail_idx]  <= 1'b1;
        exec_q[tail_idx] <= 1'b0;
        done_q[tail_idx] <= 1'b0;
        op_q[tail_idx]   <= alloc_op;
        wr_q[tail_idx]   <= alloc_wr;
        dest_q[tail_idx] <= alloc_dest;
        pa_q[tail_idx]   <= alloc_a_ready | a_hit;
        va_q[tail_idx]   <= alloc_a_ready ? alloc_a : (a_hit ? done_data : alloc_a);
        pb_q[tail_idx]   <= alloc_b_ready | b_hit;
        vb_q[tail_idx]   <= alloc_b_ready ? alloc_b : (b_hit ? done_data : alloc_b);
        tail_q <= tail_q + PTR_W'(1);
      end
      if (retire_valid) begin
        use_q[head_idx] <= 1'b0;
        head_q <= head_q + PTR_W'(1);
        if (retire_exc) begin
          use_q  <= '0;
          tail_q <= head_q + PTR_W'(1);
        end
      end
    end
  end

  a_r1_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PTR_W'(DEPTH));

  a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !retire_exc) |=> tail_q == $past(tail_q));

  a_r2_no_double_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !(issue_valid && issue_tag == $past(issue_tag)));

  a_r4_done_targets_issued: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (use_q[done_tag] && exec_q[done_tag]));

  a_r6_retire_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_exc) |=> head_q == $past(head_q) + PTR_W'(1));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    retire_exc |=> (head_q == tail_q) && (use_q == '0));

endmodule

// File: tb/ooo_issue_ring_test.sv
`timescale 1ns/1ps
module ooo_issue_ring_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       alloc_valid, alloc_ready, alloc_a_ready, alloc_b_ready, alloc_wr;
  logic [1:0] alloc_tag;
  logic [2:0] alloc_op, alloc_dest;
  logic [7:0] alloc_a, alloc_b;
  logic       issue_valid;
  logic [1:0] issue_tag;
  logic [2:0] issue_op;
  logic [7:0] issue_a, issue_b;
  logic       done_valid;
  logic [1:0] done_tag, done_cause;
  logic [7:0] done_data;
  logic       retire_valid, retire_wr, retire_exc;
  logic [1:0] retire_tag, retire_cause;
  logic [2:0] retire_dest;
  logic [7:0] retire_data;

  ooo_issue_ring uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .alloc_op(alloc_op), .alloc_a_ready(alloc_a_ready), .alloc_a(alloc_a),
    .alloc_b_ready(alloc_b_ready), .alloc_b(alloc_b), .alloc_wr(alloc_wr), .alloc_dest(alloc_dest),
    .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
    .issue_a(issue_a), .issue_b(issue_b),
    .done_valid(done_valid), .done_tag(done_tag), .done_data(done_data), .done_cause(done_cause),
    .retire_valid(retire_valid), .retire_tag(retire_tag), .retire_wr(retire_wr),
    .retire_dest(retire_dest), .retire_data(retire_data), .retire_cause(retire_cause),
    .retire_exc(retire_exc)
  );

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    alloc_valid = 1'b0;
    done_valid  = 1'b0;
  endtask

  task automatic put(int op, bit ar, int a, bit br, int b, bit wr, int dest);
    alloc_valid = 1'b1;
    alloc_op = 3'(op);
    alloc_a_ready = ar; alloc_a = 8'(a);
    alloc_b_ready = br; alloc_b = 8'(b);
    alloc_wr = wr; alloc_dest = 3'(dest);
  endtask

  task automatic fin(int t, int d, int c);
    done_valid = 1'b1;
    done_tag = 2'(t); done_data = 8'(d); done_cause = 2'(c);
  endtask

  task automatic single(int t, int a, int b);
    nxt(); put(1, 1, a, 1, b, 1, 2); #1; chk("R1 tag order", alloc_tag, t);
    nxt(); #1; chk("R2 issue", issue_valid, 1); chk("R2 issue tag", issue_tag, t);
    nxt(); fin(t, a + b, 0); #1;
    nxt(); #1; chk("R6 retire", retire_valid, 1); chk("R6 retire data", retire_data, a + b);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    alloc_valid = 0; done_valid = 0; alloc_op = 0; alloc_a_ready = 0; alloc_a = 0;
    alloc_b_ready = 0; alloc_b = 0; alloc_wr = 0; alloc_dest = 0;
    done_tag = 0; done_data = 0; done_cause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8 reset state
    chk("R8 ready", alloc_ready, 1); chk("R8 tag", alloc_tag, 0);
    chk("R8 issue", issue_valid, 0); chk("R8 retire", retire_valid, 0);

    // Phase A: fill, wake, full stall, in-order retire
    nxt(); put(1, 1, 10, 1, 20, 1, 3); #1;
    chk("R1 tag0", alloc_tag, 0); chk("R2 none yet", issue_valid, 0);
    nxt(); put(2, 1, 3, 1, 4, 1, 4); #1;
    chk("R1 tag1", alloc_tag, 1); chk("R2 issue v", issue_valid, 1);
    chk("R2 issue tag", issue_tag, 0); chk("R2 op", issue_op, 1);
    chk("R2 a", issue_a, 10); chk("R2 b", issue_b, 20);
    nxt(); put(3, 0, 1, 1, 5, 1, 5); #1;
    chk("R1 tag2", alloc_tag, 2); chk("R2 issue tag1", issue_tag, 1); chk("R2 a1", issue_a, 3);
    nxt(); put(4, 1, 7, 1, 8, 1, 6); #1;
    chk("R2 waiting not issued", issue_valid, 0);
    nxt(); put(5, 1, 200, 1, 201, 1, 7); fin(1, 99, 0); #1;
    chk("R1 full", alloc_ready, 0); chk("R2 issue tag3", issue_tag, 3); chk("R2 a3", issue_a, 7);
    nxt(); fin(0, 30, 0); #1;
    chk("R4 woken issue", issue_tag, 2); chk("R4 woken data", issue_a, 99);
    chk("R4 other operand", issue_b, 5); chk("R6 head not done", retire_valid, 0);
    nxt(); fin(3, 55, 0); #1;
    chk("R6 retire0", retire_valid, 1); chk("R6 tag0", retire_tag, 0);
    chk("R6 data0", retire_data, 30); chk("R6 dest0", retire_dest, 3);
    chk("R6 wr0", retire_wr, 1); chk("R6 no exc", retire_exc, 0);
    nxt(); #1;
    chk("R6 retire1", retire_tag, 1); chk("R6 data1", retire_data, 99);
    chk("R2 nothing left", issue_valid, 0);
    nxt(); fin(2, 77, 0); #1;
    chk("R6 younger done waits", retire_valid, 0);
    nxt(); #1; chk("R6 retire2", retire_data, 77); chk("R6 tag2", retire_tag, 2);
    nxt(); #1; chk("R6 retire3", retire_data, 55); chk("R1 full alloc ignored", retire_tag, 3);
    nxt(); #1;
    chk("R6 empty", retire_valid, 0); chk("R1 ready again", alloc_ready, 1);
    chk("R1 wrap tag", alloc_tag, 0);

    // Sweep the head forward with simple instructions
    single(0, 11, 12);
    single(1, 21, 22);

    // Phase B: wrapped oldest-first, same-cycle capture, exception flush
    nxt(); put(1, 1, 1, 1, 1, 1, 1); #1; chk("R1 tag2 wrap", alloc_tag, 2);
    nxt(); put(2, 0, 2, 1, 2, 1, 5); #1; chk("R2 P issue", issue_tag, 2);
    nxt(); put(3, 0, 2, 1, 3, 1, 6); #1; chk("R2 waiters idle", issue_valid, 0);
    nxt(); put(4, 0, 2, 1, 4, 1, 7); fin(2, 40, 0); #1;
    chk("R1 tag1 wrap", alloc_tag, 1); chk("R2 still idle", issue_valid, 0);
    nxt(); #1;
    chk("R3 oldest first", issue_tag, 3); chk("R3 data", issue_a, 40); chk("R3 b", issue_b, 2);
    chk("R1 full again", alloc_ready, 0);
    chk("R6 retire P", retire_tag, 2); chk("R6 P data", retire_data, 40);
    nxt(); fin(3, 0, 2); #1;
    chk("R3 next", issue_tag, 0); chk("R4 Z data", issue_a, 40);
    nxt(); fin(0, 9, 0); #1;
    chk("R5 same-cycle capture", issue_tag, 1); chk("R5 data", issue_a, 40);
    chk("R7 exc", retire_exc, 1); chk("R7 cause", retire_cause, 2);
    chk("R7 tag", retire_tag, 3); chk("R7 alloc blocked", alloc_ready, 0);
    nxt(); put(6, 1, 6, 1, 7, 1, 2); #1;
    chk("R7 no younger retire", retire_valid, 0); chk("R7 ready", alloc_ready, 1);
    chk("R7 next tag", alloc_tag, 0); chk("R7 no stale issue", issue_valid, 0);
    nxt(); #1;
    chk("R7 fresh issue", issue_tag, 0); chk("R7 fresh a", issue_a, 6);
    chk("R7 fresh op", issue_op, 6); chk("R7 still empty retire", retire_valid, 0);
    nxt(); fin(0, 13, 0); #1;
    nxt(); #1;
    chk("R7 fresh retire", retire_data, 13); chk("R7 fresh no exc", retire_exc, 0);
    nxt(); #1; chk("R7 drained", retire_valid, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule